// File: doc/BRIEF.md
# Interrupt Arbiter and Trap Vectoring Unit

This block decides, once per clock, whether the processor core leaves its current instruction stream for a privileged handler. It takes four asynchronous-style interrupt request lines (device, timer, interprocessor, machine check), a synchronous exception request carrying a cause code and an 8-bit argument, the current program counter, the base address of the privileged handler area, the current privileged-mode flag and a 3-bit interrupt priority level.

When a request is accepted, the unit computes the handler entry address as base plus a cause-dependent offset. It forms the saved exception address, with the previous mode folded into bit 0, and reports the core as privileged. All of this is registered, so results appear one clock after the inputs that caused them, together with a single-cycle `taken_o` pulse. Synchronous exceptions outrank interrupts. Interrupts are never accepted while privileged mode is active. System-call exceptions get one 64-byte entry slot per call number, with unprivileged calls (argument bit 7 set) placed in their own region.

Top module: `trap_vector_unit`

## Requirements
- R1: While `priv_i` is 1, no interrupt is accepted. A valid exception is still accepted in privileged mode.
- R2: Interrupt line bits in `irq_lines_i` are: bit 0 device, bit 1 timer, bit 2 interprocessor, bit 3 machine check. At levels 0 to 3 all four are eligible. Level 4 masks device. Level 5 masks device and timer. Level 6 leaves only machine check. Level 7 masks all four.
- R3: Among eligible interrupts the winner is machine check, then interprocessor, then timer, then device.
- R4: Cause codes on `exc_cause_i` and their entry offsets are: 0 reset 0x000, 1 machine check 0x080, 2 interprocessor 0x100, 3 timer 0x180, 4 device 0x200, 5 memory fault 0x280, 6 unaligned 0x300, 7 illegal opcode 0x380, 8 arithmetic 0x400, 9 FP disabled 0x480. An accepted interrupt uses the offset of its own code.
- R5: Cause code 10 is a system call with number n = `exc_arg_i`. The offset is 0x2000 + (n-0x80)*64 when bit 7 of n is set, and 0x1000 + n*64 otherwise.
- R6: On a take, `saved_o` equals the recorded PC ORed with the value of `priv_i` in bit 0.
- R7: For cause 8 (arithmetic), the recorded PC is `pc_i`+4. For every other cause and for interrupts, it is `pc_i`.
- R8: On a take, `new_pc_o` equals `base_i` plus the offset (modulo 2^64) and `mode_o` is 1. When nothing is taken, `mode_o` follows `priv_i`.
- R9: A valid exception in the same cycle as eligible interrupts is taken instead of them.
- R10: Results appear on the clock edge after the request. `taken_o` is high for exactly that one cycle per accepted request. `new_pc_o` and `saved_o` hold their values when nothing is taken.
- R11: Interrupt entries ignore `exc_arg_i`, so the interrupt's code argument is treated as zero.
- R12: Cause codes 11 to 15 are reserved. Such a request is ignored, and interrupt arbitration proceeds as if no exception were present.
- R13: While `rst` is high, `taken_o`, `mode_o`, `new_pc_o` and `saved_o` are all 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 4 | Interrupt requests: device, timer, interprocessor, machine check (bit 0 to 3) |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 4 | Exception cause code |
| exc_arg_i | input | 8 | Exception argument (system-call number) |
| pc_i | input | 64 | Current program counter |
| base_i | input | 64 | Privileged handler area base |
| priv_i | input | 1 | Current privileged-mode flag |
| ipl_i | input | 3 | Current interrupt priority level |
| taken_o | output | 1 | One-cycle pulse: a request was vectored |
| new_pc_o | output | 64 | Handler entry address |
| saved_o | output | 64 | Saved exception address with previous mode in bit 0 |
| mode_o | output | 1 | Updated privileged-mode flag |

## Verification
The hardest situation to reach is the interaction of the level mask with the priority order. A lower-priority line must win when a higher one is masked, and arbitration must ignore a reserved exception code. The stimulus therefore sweeps each line across the level at which it becomes masked. It pairs lines so that masking changes the winner, and it offers a reserved exception together with pending interrupts. System-call numbers at both region edges (0x00, 0x7F, 0x80, 0xFF) and a base that wraps past 2^64 exercise the offset arithmetic.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;

    localparam int XLEN      = 64;
    localparam int CAUSE_W   = 4;
    localparam int CALL_W    = 8;
    localparam int IPL_W     = 3;
    localparam int NUM_IRQ   = 4;
    localparam int SLOT_LG   = 6;
    localparam int FIXED_LG  = 7;
    localparam int LOW_CEIL  = 3;
    localparam int PC_STEP   = 4;
    localparam logic [XLEN-1:0] PRIV_CALL_AREA = XLEN'(32'h1000);
    localparam logic [XLEN-1:0] USER_CALL_AREA = XLEN'(32'h2000);

    typedef enum logic [CAUSE_W-1:0] {
        CZ_RESET   = 4'd0,
        CZ_MCHK    = 4'd1,
        CZ_IPI     = 4'd2,
        CZ_TIMER   = 4'd3,
        CZ_DEVICE  = 4'd4,
        CZ_MEMFLT  = 4'd5,
        CZ_UNALIGN = 4'd6,
        CZ_BADOP   = 4'd7,
        CZ_ARITH   = 4'd8,
        CZ_FPOFF   = 4'd9,
        CZ_SYSCALL = 4'd10
    } cause_e;

    typedef struct packed {
        logic               hit;
        cause_e             cause;
        logic [CALL_W-1:0]  arg;
    } vec_req_t;

    typedef struct packed {
        logic               taken;
        logic [XLEN-1:0]    entry;
        logic [XLEN-1:0]    saved;
        logic               mode;
    } vec_out_t;

    function automatic logic cause_known(input logic [CAUSE_W-1:0] c);
        return c <= CAUSE_W'(CZ_SYSCALL);
    endfunction

    // Highest priority level at which line i is still eligible.
    function automatic logic [IPL_W-1:0] line_ceiling(input int i);
        return IPL_W'(LOW_CEIL + i);
    endfunction

    function automatic cause_e line_cause(input int i);
        case (i)
            0:       return CZ_DEVICE;
            1:       return CZ_TIMER;
            2:       return CZ_IPI;
            default: return CZ_MCHK;
        endcase
    endfunction

endpackage

// File: rtl/irq_level_mask.sv
module irq_level_mask
    import trap_vec_pkg::*;
(
    input  logic [NUM_IRQ-1:0] req_i,
    input  logic [IPL_W-1:0]   ipl_i,
    input  logic               priv_i,
    output logic [NUM_IRQ-1:0] elig_o
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        assign elig_o[g] = req_i[g] && !priv_i && (ipl_i <= line_ceiling(g));
    end
endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick
    import trap_vec_pkg::*;
(
    input  logic [NUM_IRQ-1:0] elig_i,
    output logic [NUM_IRQ-1:0] grant_o,
    output logic               any_o,
    output cause_e             cause_o
);
    // Higher line index wins: later iterations override earlier ones.
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        cause_o = CZ_RESET;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
                cause_o    = line_cause(i);
            end
        end
    end
endmodule

// File: rtl/vector_offset_calc.sv
module vector_offset_calc
    import trap_vec_pkg::*;
(
    input  vec_req_t        req_i,
    output logic [XLEN-1:0] offset_o
);
    logic [CALL_W-2:0] call_slot;
    logic [XLEN-1:0]   slot_bytes;

    assign call_slot  = req_i.arg[CALL_W-2:0];
    assign slot_bytes = XLEN'(call_slot) << SLOT_LG;

    always_comb begin
        if (req_i.cause == CZ_SYSCALL) begin
            offset_o = (req_i.arg[CALL_W-1] ? USER_CALL_AREA : PRIV_CALL_AREA)
                       + slot_bytes;
        end else begin
            offset_o = XLEN'(req_i.cause) << FIXED_LG;
        end
    end
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
    import trap_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        irq_lines_i,
    input  logic              exc_valid_i,
    input  logic [3:0]        exc_cause_i,
    input  logic [7:0]        exc_arg_i,
    input  logic [63:0]       pc_i,
    input  logic [63:0]       base_i,
    input  logic              priv_i,
    input  logic [2:0]        ipl_i,
    output logic              taken_o,
    output logic [63:0]       new_pc_o,
    output logic [63:0]       saved_o,
    output logic              mode_o
);
    logic [NUM_IRQ-1:0] irq_elig;
    logic [NUM_IRQ-1:0] irq_grant;
    logic               irq_any;
    cause_e             irq_cause;
    logic               exc_ok;
    vec_req_t           sel;
    logic [XLEN-1:0]    offset;
    logic [XLEN-1:0]    rec_pc;
    vec_out_t           nxt, cur;

    irq_level_mask i_mask (
        .req_i  (irq_lines_i),
        .ipl_i  (ipl_i),
        .priv_i (priv_i),
        .elig_o (irq_elig)
    );

    irq_priority_pick i_pick (
        .elig_i  (irq_elig),
        .grant_o (irq_grant),
        .any_o   (irq_any),
        .cause_o (irq_cause)
    );

    // Reserved cause codes never count as a request.
    assign exc_ok = exc_valid_i && cause_known(exc_cause_i);

    always_comb begin
        if (exc_ok) begin
            sel = '{hit: 1'b1, cause: cause_e'(exc_cause_i), arg: exc_arg_i};
        end else if (irq_any) begin
            sel = '{hit: 1'b1, cause: irq_cause, arg: '0};
        end else begin
            sel = '{hit: 1'b0, cause: CZ_RESET, arg: '0};
        end
    end

    vector_offset_calc i_ofs (
        .req_i    (sel),
        .offset_o (offset)
    );

    assign rec_pc = (sel.cause == CZ_ARITH && exc_ok) ? pc_i + XLEN'(PC_STEP) : pc_i;

    always_comb begin
        nxt = cur;
        nxt.taken = sel.hit;
        nxt.mode  = sel.hit ? 1'b1 : priv_i;
        if (sel.hit) begin
            nxt.entry = base_i + offset;
            nxt.saved = rec_pc | XLEN'(priv_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign taken_o  = cur.taken;
    assign new_pc_o = cur.entry;
    assign saved_o  = cur.saved;
    assign mode_o   = cur.mode;

    a_r1_no_irq_in_priv: assert property (@(posedge clk) disable iff (rst)
        (priv_i && !exc_ok) |=> !taken_o);

    a_r2_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        (irq_grant & ~irq_elig) == '0);

    a_r2_level_six_mchk_only: assert property (@(posedge clk) disable iff (rst)
        (ipl_i == 3'd6) |-> (irq_elig[2:0] == 3'b000));

    a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_grant));

    a_r6_saved_mode_bit: assert property (@(posedge clk) disable iff (rst)
        (taken_o && $past(priv_i)) |-> saved_o[0]);

    a_r8_mode_set_on_take: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> mode_o);

    a_r8_entry_slot_aligned: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (new_pc_o[SLOT_LG-1:0] == $past(base_i[SLOT_LG-1:0])));

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> ($stable(new_pc_o) && $stable(saved_o)));

endmodule

// File: tb/test_trap_vector_unit.sv
`timescale 1ns/1ps
module test_trap_vector_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  irq_lines_i = '0;
    logic        exc_valid_i = 1'b0;
    logic [3:0]  exc_cause_i = '0;
    logic [7:0]  exc_arg_i = '0;
    logic [63:0] pc_i = '0;
    logic [63:0] base_i = '0;
    logic        priv_i = 1'b0;
    logic [2:0]  ipl_i = '0;
    logic        taken_o;
    logic [63:0] new_pc_o;
    logic [63:0] saved_o;
    logic        mode_o;

    trap_vector_unit i_trap_vector_unit (.*);

    always #2 clk = ~clk;

    typedef struct {
        string       tag;
        logic        tk;
        logic [63:0] pc;
        logic [63:0] sv;
        logic        md;
    } exp_t;

    exp_t        sb[$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [63:0] last_pc = '0;
    logic [63:0] last_sv = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic drive(input string tag, input logic [3:0] irq, input logic ev,
                         input logic [3:0] cz, input logic [7:0] arg,
                         input logic [63:0] pc, input logic [63:0] base,
                         input logic pv, input logic [2:0] ipl);
        exp_t        e;
        logic [63:0] ofs;
        logic [63:0] rpc;
        bit          hit;
        @(negedge clk);
        irq_lines_i = irq; exc_valid_i = ev; exc_cause_i = cz; exc_arg_i = arg;
        pc_i = pc; base_i = base; priv_i = pv; ipl_i = ipl;
        hit = 0; ofs = '0; rpc = pc;
        if (ev && cz <= 4'd10) begin
            hit = 1;
            if (cz == 4'd10)
                ofs = arg[7] ? 64'h2000 + (64'(arg) - 64'h80) * 64 : 64'h1000 + 64'(arg) * 64;
            else
                ofs = 64'(cz) * 64'h80;
            if (cz == 4'd8) rpc = pc + 64'd4;
        end else if (!pv) begin
            if (ipl <= 3'd3 && irq[0]) begin hit = 1; ofs = 64'h200; end
            if (ipl <= 3'd4 && irq[1]) begin hit = 1; ofs = 64'h180; end
            if (ipl <= 3'd5 && irq[2]) begin hit = 1; ofs = 64'h100; end
            if (ipl <= 3'd6 && irq[3]) begin hit = 1; ofs = 64'h080; end
        end
        e.tag = tag;
        e.tk  = hit;
        e.md  = hit ? 1'b1 : pv;
        if (hit) begin
            last_pc = base + ofs;
            last_sv = rpc | 64'(pv);
        end
        e.pc = last_pc;
        e.sv = last_sv;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag, input logic pv);
        drive(tag, 4'h0, 1'b0, 4'h0, 8'h00, 64'h0, 64'h0, pv, 3'd0);
    endtask

    // Monitor: pops one expected item per cycle after each edge.
    initial begin
        exp_t e;
        @(negedge rst);
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(taken_o === e.tk, e.tag, "taken", 64'(taken_o), 64'(e.tk));
                chk(mode_o === e.md, e.tag, "mode", 64'(mode_o), 64'(e.md));
                chk(new_pc_o === e.pc, e.tag, "new_pc", new_pc_o, e.pc);
                chk(saved_o === e.sv, e.tag, "saved", saved_o, e.sv);
            end
        end
    end

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    localparam logic [63:0] PC = 64'h0000_0040_0012_3450;
    localparam logic [63:0] BA = 64'h0000_0000_0001_0000;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(taken_o === 1'b0, "R13", "taken", 64'(taken_o), 64'h0);
        chk(mode_o === 1'b0, "R13", "mode", 64'(mode_o), 64'h0);
        chk(new_pc_o === 64'h0, "R13", "new_pc", new_pc_o, 64'h0);
        chk(saved_o === 64'h0, "R13", "saved", saved_o, 64'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R3 priority and level masking
        drive("R3 all lines lvl0 -> mchk", 4'hF, 0, 0, 8'h00, PC, BA, 0, 3'd0);
        drive("R10 idle after take", 4'h0, 0, 0, 8'h00, PC, BA, 0, 3'd0);
        drive("R2 device at lvl3", 4'h1, 0, 0, 8'h00, PC, BA, 0, 3'd3);
        drive("R2 device masked at lvl4", 4'h1, 0, 0, 8'h00, PC, BA, 0, 3'd4);
        drive("R2 timer at lvl4", 4'h2, 0, 0, 8'h00, PC, BA, 0, 3'd4);
        drive("R2 timer masked at lvl5", 4'h2, 0, 0, 8'h00, PC, BA, 0, 3'd5);
        drive("R2 ipi at lvl5", 4'h4, 0, 0, 8'h00, PC, BA, 0, 3'd5);
        drive("R2 ipi masked at lvl6", 4'h4, 0, 0, 8'h00, PC, BA, 0, 3'd6);
        drive("R2 mchk at lvl6", 4'h8, 0, 0, 8'h00, PC, BA, 0, 3'd6);
        drive("R2 mchk masked at lvl7", 4'h8, 0, 0, 8'h00, PC, BA, 0, 3'd7);
        drive("R3 timer over device", 4'h3, 0, 0, 8'h00, PC, BA, 0, 3'd0);
        drive("R3 ipi over device+timer", 4'h7, 0, 0, 8'h00, PC, BA, 0, 3'd2);
        drive("R2 R3 lvl5 leaves ipi over device", 4'h5, 0, 0, 8'h00, PC, BA, 0, 3'd5);
        drive("R2 lvl4 timer wins with device pending", 4'h3, 0, 0, 8'h00, PC, BA, 0, 3'd4);
        // R1 privileged mode
        drive("R1 no irq in priv", 4'hF, 0, 0, 8'h00, PC, BA, 1, 3'd0);
        drive("R1 exception in priv", 4'hF, 1, 4'd5, 8'h00, PC, BA, 1, 3'd0);
        idle("R8 mode follows input", 1);
        idle("R8 mode follows input low", 0);
        // R9 precedence, R4 fixed offsets, R6/R7 saved address
        drive("R9 memfault beats mchk", 4'hF, 1, 4'd5, 8'h00, PC, BA, 0, 3'd0);
        drive("R4 reset code", 4'h0, 1, 4'd0, 8'h00, PC, BA, 0, 3'd7);
        drive("R4 unaligned", 4'h0, 1, 4'd6, 8'h00, PC + 64'h10, BA, 0, 3'd0);
        drive("R4 illegal opcode", 4'h0, 1, 4'd7, 8'h00, PC, BA, 0, 3'd0);
        drive("R4 fp disabled", 4'h0, 1, 4'd9, 8'h00, PC, BA, 1, 3'd0);
        drive("R4 exc code device", 4'h0, 1, 4'd4, 8'h00, PC, BA, 0, 3'd7);
        drive("R7 arith next pc", 4'h0, 1, 4'd8, 8'h00, PC, BA, 0, 3'd0);
        drive("R6 R7 arith in priv", 4'h0, 1, 4'd8, 8'h00, PC, BA, 1, 3'd0);
        // R5 system calls
        drive("R5 call 0x05", 4'h0, 1, 4'd10, 8'h05, PC, BA, 0, 3'd0);
        drive("R5 call 0x00", 4'h0, 1, 4'd10, 8'h00, PC, BA, 0, 3'd0);
        drive("R5 call 0x7F", 4'h0, 1, 4'd10, 8'h7F, PC, BA, 0, 3'd0);
        drive("R5 call 0x80", 4'h0, 1, 4'd10, 8'h80, PC, BA, 0, 3'd0);
        drive("R5 call 0x83", 4'h0, 1, 4'd10, 8'h83, PC, BA, 1, 3'd0);
        drive("R5 call 0xFF", 4'h0, 1, 4'd10, 8'hFF, PC, BA, 0, 3'd0);
        drive("R8 base wraps", 4'h0, 1, 4'd10, 8'h05, PC, 64'hFFFF_FFFF_FFFF_F000, 0, 3'd0);
        // R11 interrupt ignores argument, R12 reserved codes
        drive("R11 irq ignores arg", 4'h2, 0, 4'd10, 8'hFF, PC, BA, 0, 3'd0);
        drive("R12 reserved code with device", 4'h1, 1, 4'd12, 8'h05, PC, BA, 0, 3'd0);
        drive("R12 reserved code alone", 4'h0, 1, 4'd15, 8'h05, PC, BA, 0, 3'd0);
        drive("R12 reserved code 11", 4'h0, 1, 4'd11, 8'h00, PC, BA, 1, 3'd0);
        drive("R10 back to back 1", 4'h8, 0, 0, 8'h00, PC, BA, 0, 3'd0);
        drive("R10 back to back 2", 4'h4, 0, 0, 8'h00, PC + 64'h4, BA + 64'h40, 0, 3'd0);
        idle("R10 pulse ends", 0);
        idle("R10 hold", 0);

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        #1;
        summary();
    end

endmodule